// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns six external interrupt pins into request flags for an 8-bit microcontroller core. Each pin goes through a synchronizer and is then sampled once per machine cycle, on a cycle strobe that the core supplies. Flag bit `i` belongs to pin `i`. Sources 0 and 1 are active low and have a mode bit each. A mode bit of 1 makes the source falling-edge triggered. A mode bit of 0 makes it low-level triggered. Sources 2 and 4 react only to a rising edge. Sources 3 and 5 react only to a falling edge.

The clearing rules differ by group. An edge-mode flag on source 0 or 1 is cleared by that source's service acknowledge or by a software clear. A level-mode flag tracks the sampled pin and ignores both. Flags 2 to 5 are cleared only by software. The block produces the raw request flags and a readback of the two mode bits. Priority, enable masking and vectoring are handled downstream.

Top module: `xirq_detect`

## Requirements
- R1: After reset, `irq_flag_o` is 0 and `mode_o` is 0, which is level mode for sources 0 and 1. Input samples reset to each pin's idle level (high for sources 0, 1, 3 and 5, low for sources 2 and 4), so releasing reset creates no edge.
- R2: Samples are taken only on clock edges where `mc_strobe` is 1. A pin change with no strobe leaves every flag unchanged.
- R3: Each pin passes through a two-flop synchronizer before sampling. An edge is detected only when two consecutive strobe samples differ. A pulse that starts and ends between two strobes is not detected.
- R4: Flags 2 and 4 set on a low-to-high sampled transition. A high-to-low transition does not set them.
- R5: Flags 3 and 5 set on a high-to-low sampled transition. A low-to-high transition does not set them.
- R6: With `mode_o[i]`=1 (i = 0 or 1), flag i sets on a falling sampled transition. It clears on the clock edge where `ack_i[i]`=1, or where `clr_wr`=1 with `clr_mask[i]`=1.
- R7: With `mode_o[i]`=0 (i = 0 or 1), each strobe loads flag i with the inverse of the new sample. `ack_i` and software clear have no effect, so a pin still low after service keeps the request raised.
- R8: Flags 2 to 5 are never cleared by hardware. A flag clears only on a clock edge with `clr_wr`=1 and its `clr_mask` bit set. Flags whose mask bit is 0 are unchanged, and `ack_i` does not affect flags 2 to 5.
- R9: If a set event and a clear (software or acknowledge) reach the same flag on the same clock edge, the flag ends set.
- R10: A clock edge with `mode_wr`=1 loads `mode_wdata` into the mode bits. Bit 0 controls source 0 and bit 1 controls source 1. `mode_o` reads them back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_strobe | input | 1 | Machine-cycle sampling strobe |
| pin_i | input | 6 | External interrupt pins, bit i = source i |
| mode_wr | input | 1 | Mode bits write enable |
| mode_wdata | input | 2 | New mode bits (1 = edge, 0 = level) |
| clr_wr | input | 1 | Software write-clear enable |
| clr_mask | input | 6 | Flags to clear when `clr_wr` is 1 |
| ack_i | input | 2 | Service acknowledge for sources 0 and 1 |
| irq_flag_o | output | 6 | Raw request flags |
| mode_o | output | 2 | Mode bits readback |

## Verification
Two functions can act on the same flag in one cycle: a detected edge that sets it, and a clear from software or from a service acknowledge. The bench provokes this by moving a pin one machine cycle ahead, so the new level is already through the synchronizer. It then asserts the strobe in the same clock as `clr_wr` with the matching mask bit (source 4), or as `ack_i[0]` (source 0 in edge mode). The flag must read 1 on the next cycle. A checker property also requires every set event to be followed by a set flag, whatever clear is present.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int NUM_SRC = 6;  // external interrupt sources
  localparam int NUM_SEL = 2;  // low-order sources with a mode bit

  typedef enum logic [1:0] {
    SRC_SELECTABLE = 2'd0,  // active low, edge or level by mode bit
    SRC_RISE       = 2'd1,  // rising edge only
    SRC_FALL       = 2'd2   // falling edge only
  } src_kind_e;

  // Map a source index to its kind: selectable, then alternating rise/fall.
  function automatic src_kind_e kind_of(input int idx);
    if (idx < NUM_SEL)      return SRC_SELECTABLE;
    else if (idx % 2 == 0)  return SRC_RISE;
    else                    return SRC_FALL;
  endfunction

  // Inactive level per pin: high unless the source triggers on a rising edge.
  function automatic logic [NUM_SRC-1:0] idle_levels();
    logic [NUM_SRC-1:0] v;
    for (int i = 0; i < NUM_SRC; i++) v[i] = (kind_of(i) != SRC_RISE);
    return v;
  endfunction

  localparam logic [NUM_SRC-1:0] IDLE_LEVEL = idle_levels();

  function automatic logic saw_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic saw_rise(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int              W       = 6,
  parameter int              DEPTH   = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/xirq_sampler.sv
module xirq_sampler #(
  parameter int           W       = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST_VAL;
    else if (strobe) q <= d;
  end

endmodule

// File: rtl/xirq_flag_cell.sv
module xirq_flag_cell
  import xirq_pkg::*;
#(
  parameter src_kind_e KIND = SRC_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic prev_i,       // previous machine-cycle sample
  input  logic cur_i,        // synchronized pin, next sample
  input  logic edge_mode_i,  // 1 = edge, 0 = level (selectable kind only)
  input  logic ack_i,        // service acknowledge (selectable kind only)
  input  logic clr_i,        // software clear
  output logic flag_o,
  output logic set_evt_o
);

  logic level_mode;
  logic hw_clear;

  generate
    if (KIND == SRC_SELECTABLE) begin : g_sel
      assign level_mode = ~edge_mode_i;
      assign set_evt_o  = level_mode ? (strobe & ~cur_i)
                                     : (strobe & saw_fall(prev_i, cur_i));
      assign hw_clear   = ack_i;
    end else if (KIND == SRC_RISE) begin : g_rise
      assign level_mode = 1'b0;
      assign set_evt_o  = strobe & saw_rise(prev_i, cur_i);
      assign hw_clear   = 1'b0;
    end else begin : g_fall
      assign level_mode = 1'b0;
      assign set_evt_o  = strobe & saw_fall(prev_i, cur_i);
      assign hw_clear   = 1'b0;
    end
  endgenerate

  logic unused_inputs;
  assign unused_inputs = edge_mode_i ^ ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (level_mode) begin
      if (strobe) flag_o <= ~cur_i;
    end else if (set_evt_o) begin
      flag_o <= 1'b1;  // a set beats any clear in the same cycle
    end else if (hw_clear || clr_i) begin
      flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mc_strobe,
  input  logic [NUM_SRC-1:0] pin_i,
  input  logic               mode_wr,
  input  logic [NUM_SEL-1:0] mode_wdata,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_mask,
  input  logic [NUM_SEL-1:0] ack_i,
  output logic [NUM_SRC-1:0] irq_flag_o,
  output logic [NUM_SEL-1:0] mode_o
);

  logic [NUM_SRC-1:0] sync_q;   // synchronized pins
  logic [NUM_SRC-1:0] smp_q;    // last machine-cycle sample
  logic [NUM_SRC-1:0] set_evt;  // per-source set event, brought out for checks
  logic [NUM_SEL-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= mode_wdata;
  end
  assign mode_o = mode_q;

  xirq_sync #(.W(NUM_SRC), .DEPTH(SYNC_DEPTH), .RST_VAL(IDLE_LEVEL)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_i),
    .q     (sync_q)
  );

  xirq_sampler #(.W(NUM_SRC), .RST_VAL(IDLE_LEVEL)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (mc_strobe),
    .d      (sync_q),
    .q      (smp_q)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic mode_bit;
    logic ack_bit;
    if (g < NUM_SEL) begin : g_ctl
      assign mode_bit = mode_q[g];
      assign ack_bit  = ack_i[g];
    end else begin : g_noctl
      assign mode_bit = 1'b1;
      assign ack_bit  = 1'b0;
    end

    xirq_flag_cell #(.KIND(kind_of(g))) u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe      (mc_strobe),
      .prev_i      (smp_q[g]),
      .cur_i       (sync_q[g]),
      .edge_mode_i (mode_bit),
      .ack_i       (ack_bit),
      .clr_i       (clr_wr & clr_mask[g]),
      .flag_o      (irq_flag_o[g]),
      .set_evt_o   (set_evt[g])
    );
  end

endmodule

// File: rtl/xirq_detect_chk.sv
module xirq_detect_chk
  import xirq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mc_strobe,
  input logic               mode_wr,
  input logic [NUM_SEL-1:0] mode_wdata,
  input logic               clr_wr,
  input logic [NUM_SRC-1:0] clr_mask,
  input logic [NUM_SEL-1:0] ack_i,
  input logic [NUM_SRC-1:0] irq_flag_o,
  input logic [NUM_SEL-1:0] mode_o,
  input logic [NUM_SRC-1:0] set_evt,
  input logic [NUM_SRC-1:0] smp_q
);

  a_r2_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_strobe |=> $stable(smp_q));

  a_r10_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_o == $past(mode_wdata)));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[g] |=> irq_flag_o[g]);

    // R4 and R5: a flag only rises from a qualifying event
    a_r4_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag_o[g]) |-> $past(set_evt[g]));

    if (g < NUM_SEL) begin : g_sel
      a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[g] && ack_i[g] && !set_evt[g]) |=> !irq_flag_o[g]);

      a_r7_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o[g] && mc_strobe && !set_evt[g]) |=> !irq_flag_o[g]);
    end else begin : g_fixed
      a_r8_sw_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag_o[g]) |-> $past(clr_wr && clr_mask[g]));
    end
  end

endmodule

bind xirq_detect xirq_detect_chk u_chk (.*);

// File: tb/xirq_detect_tb.sv
`timescale 1ns/100ps
module xirq_detect_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_strobe = 1'b0;
  logic [5:0] pin_i = 6'b101011;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic       clr_wr = 1'b0;
  logic [5:0] clr_mask = 6'b0;
  logic [1:0] ack_i = 2'b00;
  logic [5:0] irq_flag_o;
  logic [1:0] mode_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xirq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe), .pin_i(pin_i),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .ack_i(ack_i), .irq_flag_o(irq_flag_o), .mode_o(mode_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // One machine cycle: a strobe edge followed by three plain edges.
  task automatic mcycle(input int n);
    for (int k = 0; k < n; k++) begin
      mc_strobe = 1'b1;
      @(posedge clk); @(negedge clk);
      mc_strobe = 1'b0;
      idle(3);
    end
  endtask

  task automatic sw_clear(input logic [5:0] m);
    clr_wr = 1'b1; clr_mask = m;
    @(posedge clk); @(negedge clk);
    clr_wr = 1'b0; clr_mask = '0;
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_wr = 1'b1; mode_wdata = m;
    @(posedge clk); @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic pulse_ack(input logic [1:0] a);
    ack_i = a;
    @(posedge clk); @(negedge clk);
    ack_i = 2'b00;
  endtask

  task automatic t_reset;
    check("R1 flags after reset", {2'b0, irq_flag_o}, 8'h00);
    check("R1 mode after reset", {6'b0, mode_o}, 8'h00);
    mcycle(2);
    check("R1 no false edge at reset release", {2'b0, irq_flag_o}, 8'h00);
  endtask

  task automatic t_mode_write;
    write_mode(2'b10);
    check("R10 mode readback 10", {6'b0, mode_o}, 8'h02);
    write_mode(2'b00);
    check("R10 mode readback 00", {6'b0, mode_o}, 8'h00);
  endtask

  task automatic t_rise_sources;
    pin_i[2] = 1'b1; pin_i[4] = 1'b1;
    idle(10);
    check("R2 no flag without strobe", {2'b0, irq_flag_o}, 8'h00);
    mcycle(2);
    check("R4 rising sets flags 2 and 4", {2'b0, irq_flag_o}, 8'h14);
    pin_i[2] = 1'b0; pin_i[4] = 1'b0;
    mcycle(2);
    check("R8 flags 2 and 4 hold", {2'b0, irq_flag_o}, 8'h14);
    sw_clear(6'b010100);
    mcycle(2);
    check("R4 falling does not set 2 and 4", {2'b0, irq_flag_o}, 8'h00);
  endtask

  task automatic t_fall_sources;
    pin_i[3] = 1'b0;
    mcycle(1);
    check("R3 synchronizer delays detection", {2'b0, irq_flag_o}, 8'h00);
    pin_i[5] = 1'b0;
    mcycle(2);
    check("R5 falling sets flags 3 and 5", {2'b0, irq_flag_o}, 8'h28);
    pulse_ack(2'b11);
    mcycle(1);
    check("R8 ack leaves flags 3 and 5", {2'b0, irq_flag_o}, 8'h28);
    sw_clear(6'b001000);
    check("R8 masked clear only hits flag 3", {2'b0, irq_flag_o}, 8'h20);
    pin_i[3] = 1'b1; pin_i[5] = 1'b1;
    mcycle(2);
    check("R5 rising does not set 3", {2'b0, irq_flag_o}, 8'h20);
    sw_clear(6'b100000);
    check("R8 clear flag 5", {2'b0, irq_flag_o}, 8'h00);
  endtask

  task automatic t_short_pulse;
    pin_i[5] = 1'b0;
    idle(1);
    pin_i[5] = 1'b1;
    idle(5);
    mcycle(3);
    check("R3 pulse between strobes missed", {2'b0, irq_flag_o}, 8'h00);
  endtask

  task automatic t_edge_mode;
    write_mode(2'b11);
    pin_i[0] = 1'b0;
    mcycle(2);
    check("R6 falling sets flag 0", {2'b0, irq_flag_o}, 8'h01);
    pulse_ack(2'b01);
    check("R6 ack clears flag 0", {2'b0, irq_flag_o}, 8'h00);
    mcycle(2);
    check("R6 held low gives no new edge", {2'b0, irq_flag_o}, 8'h00);
    pin_i[0] = 1'b1; pin_i[1] = 1'b0;
    mcycle(2);
    check("R6 falling sets flag 1", {2'b0, irq_flag_o}, 8'h02);
    sw_clear(6'b000010);
    check("R6 software clears flag 1", {2'b0, irq_flag_o}, 8'h00);
    pin_i[1] = 1'b1;
    mcycle(2);
  endtask

  task automatic t_level_mode;
    write_mode(2'b00);
    pin_i[1] = 1'b0;
    mcycle(2);
    check("R7 low level sets flag 1", {2'b0, irq_flag_o}, 8'h02);
    pulse_ack(2'b10);
    sw_clear(6'b000010);
    check("R7 ack and clear ignored", {2'b0, irq_flag_o}, 8'h02);
    mcycle(1);
    check("R7 still low keeps request", {2'b0, irq_flag_o}, 8'h02);
    pin_i[1] = 1'b1;
    mcycle(2);
    check("R7 flag follows pin high", {2'b0, irq_flag_o}, 8'h00);
  endtask

  task automatic t_set_wins;
    pin_i[4] = 1'b1;
    mcycle(1);
    mc_strobe = 1'b1; clr_wr = 1'b1; clr_mask = 6'b010000;
    @(posedge clk); @(negedge clk);
    mc_strobe = 1'b0; clr_wr = 1'b0; clr_mask = '0;
    check("R9 set beats software clear", {2'b0, irq_flag_o}, 8'h10);
    write_mode(2'b01);
    pin_i[0] = 1'b0;
    mcycle(1);
    mc_strobe = 1'b1; ack_i = 2'b01;
    @(posedge clk); @(negedge clk);
    mc_strobe = 1'b0; ack_i = 2'b00;
    check("R9 set beats acknowledge", {2'b0, irq_flag_o}, 8'h11);
    pin_i[0] = 1'b1; pin_i[4] = 1'b0;
    sw_clear(6'b111111);
    mcycle(2);
    check("R9 all cleared after", {2'b0, irq_flag_o}, 8'h00);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_mode_write();
    t_rise_sources();
    t_fall_sources();
    t_short_pulse();
    t_edge_mode();
    t_level_mode();
    t_set_wins();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule